// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block applies, in one clock edge, every architectural state change that a 32-bit core with a branch delay slot makes when it takes a fault. The pipeline raises one or more bits of a fault request vector. It also supplies the faulting instruction address, the address that was due to run next, the offending virtual address, the address-space identifier and, for a coprocessor fault, the coprocessor number. The block keeps the exception-related system registers: the status word, the cause word, the exception return address, the bad-address register, the translation-miss key, the page-table context and the shadow register-set control. It then emits a redirected fetch triple: the handler address, handler+4 and handler+8.

When several requests arrive in the same cycle, a fixed priority picks one of them. The handler address depends on the kind of fault, on the exception-level bit as it stood before the entry, on the boot-vector bit and on the interrupt-vector bit. Software reads and writes the registers through a simple select/data port. In a cycle where a fault is taken, the fault update wins over a software write.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bit positions are 0 reset, 1 load address error, 2 store address error, 3 instruction-TLB refill, 4 instruction-TLB invalid, 5 data-TLB refill, 6 data-TLB invalid, 7 TLB modified, 8 system call, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 arithmetic overflow, 13 trap, 14 interrupt. When several bits are set, the lowest set position is taken.
- R2: The cause code field (cause bits 6:2) is loaded with: 0x4 load address, 0x5 store address, 0x2 either instruction-TLB fault, 0x3 either data-TLB fault, 0x1 TLB modified, 0x8 system call, 0x9 breakpoint, 0xA reserved instruction, 0xB coprocessor unusable, 0xC arithmetic, 0xD trap, 0xA interrupt.
- R3: Every taken fault other than reset sets the exception-level bit (status bit 1), whatever its previous value.
- R4: The shadow control word has exception set at bits 15:12, previous set at bits 9:6 and current set at bits 3:0. On a non-reset entry with exception-level and boot-vector bits (status bit 22) both clear, previous takes current and current takes exception set. Otherwise the word is left unchanged.
- R5: If the next address differs from the faulting address + 4, the return address becomes the faulting address − 4 and the delay-slot flag (cause bit 31) is set. Otherwise the return address becomes the faulting address and the flag is cleared.
- R6: The coprocessor field (cause bits 29:28) is cleared on every non-reset entry, except that a coprocessor-unusable fault loads it with the supplied coprocessor number.
- R7: With base B (base register), a fault vectors to B+0x180. The exception is the two refill faults, which vector to B+0x000 when the exception-level bit was 0 before the entry and to B+0x180 when it was already 1.
- R8: An interrupt vectors to B+0x200 when the interrupt-vector bit (cause bit 23) is 1 and to B+0x180 when it is 0. An arithmetic fault with the boot-vector bit set vectors to 0xBFC00200.
- R9: The cycle after a request, redir_valid is 1 for exactly one cycle, and redir_pc, redir_npc and redir_nnpc hold the target, target+4 and target+8.
- R10: Address and TLB faults load the bad-address register with the faulting address. TLB faults also load the miss key (address bits 31:13 at bits 31:13, identifier at bits 7:0) and the context page-number field (address bits 31:13 at context bits 22:4). Other faults leave these registers unchanged.
- R11: A reset request redirects to 0xBFC00000, +4, +8 and sets the coprocessor-1 usable bit (status bit 29). It changes no other register.
- R12: After hardware reset, status reads 0x00400000, the base reads 0x80000000, all other registers read 0 and redir_valid is 0.
- R13: Register select 0 status, 1 cause, 2 return address, 3 bad address, 4 miss key, 5 context, 6 shadow control, 7 base. Writes reach only the status bits 29/22/1, cause bit 23, the whole return address, the miss-key fields, context bits 31:23, the shadow fields and base bits 29:12. Base bits 31:30 always read 2'b10. The bad-address register is read-only, and a write in a fault cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_req | input | 15 | Fault request vector, one bit per fault kind |
| flt_pc | input | 32 | Address of the faulting instruction |
| flt_npc | input | 32 | Address due to execute next |
| flt_badva | input | 32 | Offending virtual address |
| flt_asid | input | 8 | Address-space identifier of the access |
| flt_cop | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Software register select |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data of the selected register |
| redir_valid | output | 1 | One-cycle pulse: redirect triple is new |
| redir_pc | output | 32 | Handler address |
| redir_npc | output | 32 | Handler address + 4 |
| redir_nnpc | output | 32 | Handler address + 8 |

## Verification
The faults are fired from both sequential and delay-slot positions. A delay-slot fault is the only case where the return address and the flag differ from the plain copy. Refill faults are taken once with the exception-level bit set and once with it clear, so that the offset zero vector is told apart from the general one. The shadow swap is tried with the boot-vector bit set and with both bits clear. Interrupts are taken with each interrupt-vector setting and arithmetic faults with each boot-vector setting. Mixed request vectors show that the priority order holds, and a software write issued in a fault cycle shows that the fault update wins.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;

    localparam int XW      = 32;
    localparam int ASID_W  = 8;
    localparam int VPN2_W  = 19;
    localparam int SRS_W   = 4;
    localparam int COP_W   = 2;
    localparam int CODE_W  = 5;
    localparam int EBH_W   = 18;
    localparam int PTE_W   = 9;
    localparam int NUM_FAULTS = 15;
    localparam int KIND_W  = $clog2(NUM_FAULTS);

    typedef enum logic [KIND_W-1:0] {
        FK_RESET       = 4'd0,
        FK_ADDR_LD     = 4'd1,
        FK_ADDR_ST     = 4'd2,
        FK_ITLB_REFILL = 4'd3,
        FK_ITLB_INV    = 4'd4,
        FK_DTLB_REFILL = 4'd5,
        FK_DTLB_INV    = 4'd6,
        FK_TLB_MOD     = 4'd7,
        FK_SYSCALL     = 4'd8,
        FK_BREAK       = 4'd9,
        FK_RSVD        = 4'd10,
        FK_COP         = 4'd11,
        FK_ARITH       = 4'd12,
        FK_TRAP        = 4'd13,
        FK_INTR        = 4'd14
    } fault_kind_e;

    typedef enum logic [2:0] {
        RS_STATUS  = 3'd0,
        RS_CAUSE   = 3'd1,
        RS_EPC     = 3'd2,
        RS_BADVA   = 3'd3,
        RS_MISSKEY = 3'd4,
        RS_CONTEXT = 3'd5,
        RS_SHADOW  = 3'd6,
        RS_BASE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic cu1;
        logic bev;
        logic exl;
    } status_t;

    typedef struct packed {
        logic              bd;
        logic [COP_W-1:0]  ce;
        logic              iv;
        logic [CODE_W-1:0] code;
    } cause_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
    } misskey_t;

    typedef struct packed {
        logic [PTE_W-1:0]  ptebase;
        logic [VPN2_W-1:0] badvpn2;
    } context_t;

    typedef struct packed {
        logic [SRS_W-1:0] ess;
        logic [SRS_W-1:0] pss;
        logic [SRS_W-1:0] css;
    } shadow_t;

    typedef struct packed {
        status_t          status;
        cause_t           cause;
        logic [XW-1:0]    epc;
        logic [XW-1:0]    badva;
        misskey_t         misskey;
        context_t         ctx;
        shadow_t          shadow;
        logic [EBH_W-1:0] ebase_hi;
        logic             redir_v;
        logic [XW-1:0]    pc;
        logic [XW-1:0]    npc;
        logic [XW-1:0]    nnpc;
    } ctl_state_t;

    function automatic logic [CODE_W-1:0] fault_code(fault_kind_e k);
        case (k)
            FK_TLB_MOD:                  fault_code = 5'h01;
            FK_ITLB_REFILL, FK_ITLB_INV: fault_code = 5'h02;
            FK_DTLB_REFILL, FK_DTLB_INV: fault_code = 5'h03;
            FK_ADDR_LD:                  fault_code = 5'h04;
            FK_ADDR_ST:                  fault_code = 5'h05;
            FK_SYSCALL:                  fault_code = 5'h08;
            FK_BREAK:                    fault_code = 5'h09;
            FK_RSVD, FK_INTR:            fault_code = 5'h0A;
            FK_COP:                      fault_code = 5'h0B;
            FK_ARITH:                    fault_code = 5'h0C;
            FK_TRAP:                     fault_code = 5'h0D;
            default:                     fault_code = 5'h00;
        endcase
    endfunction

    function automatic logic is_tlb_kind(fault_kind_e k);
        is_tlb_kind = (k == FK_ITLB_REFILL) || (k == FK_ITLB_INV) ||
                      (k == FK_DTLB_REFILL) || (k == FK_DTLB_INV) ||
                      (k == FK_TLB_MOD);
    endfunction

    function automatic logic is_refill_kind(fault_kind_e k);
        is_refill_kind = (k == FK_ITLB_REFILL) || (k == FK_DTLB_REFILL);
    endfunction

endpackage

// File: rtl/exc_prio_enc.sv
`timescale 1ns/1ps
module exc_prio_enc #(
    parameter int N = 15,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set position wins: scan from the top so the last hit is the lowest.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/exc_slot_detect.sv
`timescale 1ns/1ps
module exc_slot_detect #(
    parameter int XW   = 32,
    parameter int STEP = 4
) (
    input  logic [XW-1:0] pc,
    input  logic [XW-1:0] npc,
    output logic          in_slot,
    output logic [XW-1:0] ret_addr
);
    logic [XW-1:0] seq_next;

    always_comb begin
        seq_next = pc + XW'(STEP);
        in_slot  = (seq_next != npc);
        ret_addr = in_slot ? (pc - XW'(STEP)) : pc;
    end
endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] ARITH_BOOT_VEC = 32'hBFC0_0200,
    parameter logic [XW-1:0] GEN_OFS        = 32'h0000_0180,
    parameter logic [XW-1:0] INTR_OFS       = 32'h0000_0200
) (
    input  fault_kind_e   kind,
    input  logic          exl_prev,
    input  logic          bev,
    input  logic          iv,
    input  logic [XW-1:0] base,
    output logic [XW-1:0] vec
);
    always_comb begin
        vec = base + GEN_OFS;
        if (is_refill_kind(kind) && !exl_prev) begin
            vec = base;
        end else if (kind == FK_INTR && iv) begin
            vec = base + INTR_OFS;
        end else if (kind == FK_ARITH && bev) begin
            vec = ARITH_BOOT_VEC;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [XW-1:0] RESET_VEC      = 32'hBFC0_0000,
    parameter logic [XW-1:0] ARITH_BOOT_VEC = 32'hBFC0_0200,
    parameter int            STEP           = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] flt_req,
    input  logic [XW-1:0]         flt_pc,
    input  logic [XW-1:0]         flt_npc,
    input  logic [XW-1:0]         flt_badva,
    input  logic [ASID_W-1:0]     flt_asid,
    input  logic [COP_W-1:0]      flt_cop,
    input  logic                  sw_we,
    input  logic [2:0]            sw_sel,
    input  logic [XW-1:0]         sw_wdata,
    output logic [XW-1:0]         sw_rdata,
    output logic                  redir_valid,
    output logic [XW-1:0]         redir_pc,
    output logic [XW-1:0]         redir_npc,
    output logic [XW-1:0]         redir_nnpc
);
    localparam int PAGE_LSB = XW - VPN2_W;

    ctl_state_t cur_q, nxt_d;

    logic              take;
    logic [KIND_W-1:0] kind_idx;
    fault_kind_e       kind;
    logic              in_slot;
    logic [XW-1:0]     ret_addr;
    logic [XW-1:0]     base;
    logic [XW-1:0]     vec;

    exc_prio_enc #(.N(NUM_FAULTS)) u_prio (
        .req (flt_req),
        .any (take),
        .idx (kind_idx)
    );

    assign kind = fault_kind_e'(kind_idx);
    assign base = {2'b10, cur_q.ebase_hi, 12'h000};

    exc_slot_detect #(.XW(XW), .STEP(STEP)) u_slot (
        .pc       (flt_pc),
        .npc      (flt_npc),
        .in_slot  (in_slot),
        .ret_addr (ret_addr)
    );

    exc_vector_sel #(.ARITH_BOOT_VEC(ARITH_BOOT_VEC)) u_vec (
        .kind     (kind),
        .exl_prev (cur_q.status.exl),
        .bev      (cur_q.status.bev),
        .iv       (cur_q.cause.iv),
        .base     (base),
        .vec      (vec)
    );

    // Next-state computation: fault entry takes precedence over software writes.
    always_comb begin
        nxt_d         = cur_q;
        nxt_d.redir_v = 1'b0;
        if (take) begin
            nxt_d.redir_v = 1'b1;
            if (kind == FK_RESET) begin
                nxt_d.pc         = RESET_VEC;
                nxt_d.npc        = RESET_VEC + XW'(STEP);
                nxt_d.nnpc       = RESET_VEC + XW'(2 * STEP);
                nxt_d.status.cu1 = 1'b1;
            end else begin
                if (!cur_q.status.exl && !cur_q.status.bev) begin
                    nxt_d.shadow.pss = cur_q.shadow.css;
                    nxt_d.shadow.css = cur_q.shadow.ess;
                end
                nxt_d.status.exl = 1'b1;
                nxt_d.epc        = ret_addr;
                nxt_d.cause.bd   = in_slot;
                nxt_d.cause.code = fault_code(kind);
                nxt_d.cause.ce   = (kind == FK_COP) ? flt_cop : '0;
                if (is_tlb_kind(kind) || kind == FK_ADDR_LD || kind == FK_ADDR_ST) begin
                    nxt_d.badva = flt_badva;
                end
                if (is_tlb_kind(kind)) begin
                    nxt_d.misskey.vpn2  = flt_badva[XW-1:PAGE_LSB];
                    nxt_d.misskey.asid  = flt_asid;
                    nxt_d.ctx.badvpn2   = flt_badva[XW-1:PAGE_LSB];
                end
                nxt_d.pc   = vec;
                nxt_d.npc  = vec + XW'(STEP);
                nxt_d.nnpc = vec + XW'(2 * STEP);
            end
        end else if (sw_we) begin
            case (reg_sel_e'(sw_sel))
                RS_STATUS: begin
                    nxt_d.status.cu1 = sw_wdata[29];
                    nxt_d.status.bev = sw_wdata[22];
                    nxt_d.status.exl = sw_wdata[1];
                end
                RS_CAUSE:   nxt_d.cause.iv = sw_wdata[23];
                RS_EPC:     nxt_d.epc = sw_wdata;
                RS_MISSKEY: begin
                    nxt_d.misskey.vpn2 = sw_wdata[XW-1:PAGE_LSB];
                    nxt_d.misskey.asid = sw_wdata[ASID_W-1:0];
                end
                RS_CONTEXT: nxt_d.ctx.ptebase = sw_wdata[XW-1:XW-PTE_W];
                RS_SHADOW: begin
                    nxt_d.shadow.ess = sw_wdata[15:12];
                    nxt_d.shadow.pss = sw_wdata[9:6];
                    nxt_d.shadow.css = sw_wdata[3:0];
                end
                RS_BASE:    nxt_d.ebase_hi = sw_wdata[29:12];
                default:    nxt_d = nxt_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q            <= '0;
            cur_q.status.bev <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // Software read view.
    always_comb begin
        sw_rdata = '0;
        case (reg_sel_e'(sw_sel))
            RS_STATUS: begin
                sw_rdata[29] = cur_q.status.cu1;
                sw_rdata[22] = cur_q.status.bev;
                sw_rdata[1]  = cur_q.status.exl;
            end
            RS_CAUSE: begin
                sw_rdata[31]    = cur_q.cause.bd;
                sw_rdata[29:28] = cur_q.cause.ce;
                sw_rdata[23]    = cur_q.cause.iv;
                sw_rdata[6:2]   = cur_q.cause.code;
            end
            RS_EPC:     sw_rdata = cur_q.epc;
            RS_BADVA:   sw_rdata = cur_q.badva;
            RS_MISSKEY: begin
                sw_rdata[XW-1:PAGE_LSB] = cur_q.misskey.vpn2;
                sw_rdata[ASID_W-1:0]    = cur_q.misskey.asid;
            end
            RS_CONTEXT: begin
                sw_rdata[XW-1:XW-PTE_W] = cur_q.ctx.ptebase;
                sw_rdata[22:4]          = cur_q.ctx.badvpn2;
            end
            RS_SHADOW: begin
                sw_rdata[15:12] = cur_q.shadow.ess;
                sw_rdata[9:6]   = cur_q.shadow.pss;
                sw_rdata[3:0]   = cur_q.shadow.css;
            end
            RS_BASE:    sw_rdata = base;
            default:    sw_rdata = '0;
        endcase
    end

    assign redir_valid = cur_q.redir_v;
    assign redir_pc    = cur_q.pc;
    assign redir_npc   = cur_q.npc;
    assign redir_nnpc  = cur_q.nnpc;

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk
    import exc_pkg::*;
#(
    parameter int STEP = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FAULTS-1:0] flt_req,
    input logic [XW-1:0]         flt_pc,
    input logic [XW-1:0]         flt_npc,
    input logic                  redir_valid,
    input logic [XW-1:0]         redir_pc,
    input logic [XW-1:0]         redir_npc,
    input logic [XW-1:0]         redir_nnpc,
    input logic                  st_exl,
    input logic                  st_bev,
    input logic [3*SRS_W-1:0]    shadow_bits,
    input logic                  cause_bd,
    input logic [COP_W-1:0]      cause_ce,
    input logic [XW-1:0]         epc
);
    logic non_reset_entry;
    assign non_reset_entry = (|flt_req[NUM_FAULTS-1:1]) && !flt_req[0];

    AST_EXL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        non_reset_entry |=> st_exl) else $error("exl not set");  // R3

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (non_reset_entry && (st_exl || st_bev)) |=> $stable(shadow_bits))
        else $error("shadow changed");  // R4

    AST_SLOT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (non_reset_entry && (flt_npc != flt_pc + XW'(STEP)))
        |=> (cause_bd && epc == $past(flt_pc) - XW'(STEP)))
        else $error("slot return wrong");  // R5

    AST_CE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (non_reset_entry && !flt_req[FK_COP]) |=> (cause_ce == '0))
        else $error("ce not cleared");  // R6

    AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_req) |=> redir_valid) else $error("no redirect");  // R9

    AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flt_req) |=> !redir_valid) else $error("spurious redirect");  // R9

    AST_TRIPLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_npc == redir_pc + XW'(STEP) &&
                         redir_nnpc == redir_pc + XW'(2 * STEP)))
        else $error("triple spacing");  // R9
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.STEP(STEP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_req     (flt_req),
    .flt_pc      (flt_pc),
    .flt_npc     (flt_npc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .redir_npc   (redir_npc),
    .redir_nnpc  (redir_nnpc),
    .st_exl      (cur_q.status.exl),
    .st_bev      (cur_q.status.bev),
    .shadow_bits (cur_q.shadow),
    .cause_bd    (cur_q.cause.bd),
    .cause_ce    (cur_q.cause.ce),
    .epc         (cur_q.epc)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] flt_req = '0;
    logic [31:0] flt_pc = '0, flt_npc = '0, flt_badva = '0;
    logic [7:0]  flt_asid = '0;
    logic [1:0]  flt_cop = '0;
    logic        sw_we = 1'b0;
    logic [2:0]  sw_sel = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc, redir_npc, redir_nnpc;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .flt_req(flt_req), .flt_pc(flt_pc),
        .flt_npc(flt_npc), .flt_badva(flt_badva), .flt_asid(flt_asid),
        .flt_cop(flt_cop), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .redir_npc(redir_npc), .redir_nnpc(redir_nnpc)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        sw_sel = sel;
        #0.1;
        v = sw_rdata;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Drive a request for one cycle; returns at the negedge after the update.
    task automatic fire(input logic [14:0] req, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [31:0] va, input logic [7:0] asid, input logic [1:0] cop);
        @(negedge clk);
        flt_req = req; flt_pc = pc; flt_npc = npc; flt_badva = va;
        flt_asid = asid; flt_cop = cop;
        @(negedge clk);
        flt_req = '0; sw_we = 1'b0;
    endtask

    task automatic expect_vec(input string tag, input logic [31:0] v);
        chk({tag, " valid"}, {31'd0, redir_valid}, 32'd1);
        chk({tag, " pc"}, redir_pc, v);
        chk({tag, " npc"}, redir_npc, v + 32'd4);
        chk({tag, " nnpc"}, redir_nnpc, v + 32'd8);
    endtask

    task automatic t_reset_state;
        logic [31:0] v;
        chk("R12 redir_valid", {31'd0, redir_valid}, 32'd0);
        rd(3'd0, v); chk("R12 status", v, 32'h0040_0000);
        rd(3'd7, v); chk("R12 base", v, 32'h8000_0000);
        rd(3'd1, v); chk("R12 cause", v, 32'h0);
        rd(3'd2, v); chk("R12 epc", v, 32'h0);
    endtask

    task automatic t_reset_request;
        logic [31:0] v;
        fire(15'h0001, 32'h0, 32'h4, 32'h0, 8'h0, 2'd0);
        expect_vec("R11 reset", 32'hBFC0_0000);
        rd(3'd0, v); chk("R11 status cu1", v, 32'h2040_0000);
        rd(3'd2, v); chk("R11 epc untouched", v, 32'h0);
        @(negedge clk);
        chk("R9 pulse ends", {31'd0, redir_valid}, 32'd0);
    endtask

    task automatic t_syscall_boot;
        logic [31:0] v;
        wr(3'd6, 32'h0000_5002);
        fire(15'h0100, 32'h400, 32'h404, 32'h0, 8'h0, 2'd0);
        expect_vec("R7 syscall", 32'h8000_0180);
        rd(3'd1, v); chk("R2 syscall code", v, 32'h0000_0020);
        rd(3'd2, v); chk("R5 seq epc", v, 32'h400);
        rd(3'd0, v); chk("R3 exl set", v, 32'h2040_0002);
        rd(3'd6, v); chk("R4 shadow held bev", v, 32'h0000_5002);
        rd(3'd3, v); chk("R10 badva untouched", v, 32'h0);
    endtask

    task automatic t_break_slot;
        logic [31:0] v;
        wr(3'd0, 32'h2000_0000);
        wr(3'd7, 32'h1234_5000);
        rd(3'd7, v); chk("R13 base write", v, 32'h9234_5000);
        fire(15'h0200, 32'h1000, 32'h2000, 32'h0, 8'h0, 2'd0);
        expect_vec("R7 break", 32'h9234_5180);
        rd(3'd2, v); chk("R5 slot epc", v, 32'h0FFC);
        rd(3'd1, v); chk("R5 bd cause", v, 32'h8000_0024);
        rd(3'd6, v); chk("R4 shadow swap", v, 32'h0000_5085);
    endtask

    task automatic t_refill;
        logic [31:0] v;
        fire(15'h0008, 32'h3000, 32'h3004, 32'h7FFF_E123, 8'h5A, 2'd0);
        expect_vec("R7 irefill exl1", 32'h9234_5180);
        rd(3'd1, v); chk("R2 itlb code", v, 32'h0000_0008);
        rd(3'd3, v); chk("R10 badva", v, 32'h7FFF_E123);
        rd(3'd4, v); chk("R10 misskey", v, 32'h7FFF_E05A);
        rd(3'd5, v); chk("R10 context", v, 32'h003F_FFF0);
        rd(3'd6, v); chk("R4 shadow held exl", v, 32'h0000_5085);
        wr(3'd0, 32'h2000_0000);
        fire(15'h0020, 32'h3100, 32'h3104, 32'h0040_4000, 8'h11, 2'd0);
        expect_vec("R7 drefill exl0", 32'h9234_5000);
        rd(3'd1, v); chk("R2 dtlb code", v, 32'h0000_000C);
        rd(3'd6, v); chk("R4 shadow swap2", v, 32'h0000_5145);
    endtask

    task automatic t_arith_intr;
        logic [31:0] v;
        wr(3'd0, 32'h2040_0002);
        fire(15'h1000, 32'h600, 32'h604, 32'h0, 8'h0, 2'd0);
        expect_vec("R8 arith bev", 32'hBFC0_0200);
        rd(3'd1, v); chk("R2 arith code", v, 32'h0000_0030);
        wr(3'd0, 32'h2000_0000);
        fire(15'h1000, 32'h600, 32'h604, 32'h0, 8'h0, 2'd0);
        expect_vec("R8 arith nobev", 32'h9234_5180);
        fire(15'h4000, 32'h700, 32'h704, 32'h0, 8'h0, 2'd0);
        expect_vec("R8 intr iv0", 32'h9234_5180);
        rd(3'd1, v); chk("R2 intr code", v, 32'h0000_0028);
        wr(3'd1, 32'h0080_0000);
        fire(15'h4000, 32'h700, 32'h704, 32'h0, 8'h0, 2'd0);
        expect_vec("R8 intr iv1", 32'h9234_5200);
        rd(3'd1, v); chk("R8 cause iv", v, 32'h0080_0028);
    endtask

    task automatic t_cop;
        logic [31:0] v;
        fire(15'h0800, 32'h800, 32'h804, 32'h0, 8'h0, 2'd3);
        rd(3'd1, v); chk("R6 cop ce", v, 32'h3080_002C);
        fire(15'h0100, 32'h800, 32'h804, 32'h0, 8'h0, 2'd3);
        rd(3'd1, v); chk("R6 ce cleared", v, 32'h0080_0020);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        fire(15'h4102, 32'h900, 32'h904, 32'h0000_0ABC, 8'h22, 2'd0);
        rd(3'd1, v); chk("R1 addr wins", v, 32'h0080_0010);
        rd(3'd3, v); chk("R10 addr badva", v, 32'h0000_0ABC);
        rd(3'd4, v); chk("R10 misskey kept", v, 32'h0040_4011);
        fire(15'h0005, 32'hA00, 32'hA04, 32'h0, 8'h0, 2'd0);
        expect_vec("R1 reset wins", 32'hBFC0_0000);
        rd(3'd1, v); chk("R11 cause kept", v, 32'h0080_0010);
    endtask

    task automatic t_sw_port;
        logic [31:0] v;
        wr(3'd3, 32'h5555_5555);
        rd(3'd3, v); chk("R13 badva read-only", v, 32'h0000_0ABC);
        wr(3'd2, 32'h1111_2220);
        rd(3'd2, v); chk("R13 epc write", v, 32'h1111_2220);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = 3'd2; sw_wdata = 32'hDEAD_0000;
        fire(15'h2000, 32'h5000, 32'h5004, 32'h0, 8'h0, 2'd0);
        rd(3'd2, v); chk("R13 fault beats write", v, 32'h5000);
        rd(3'd1, v); chk("R2 trap code", v, 32'h0080_0034);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_request();
        t_syscall_boot();
        t_break_slot();
        t_refill();
        t_arith_intr();
        t_cop();
        t_priority();
        t_sw_port();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule